// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block turns a device DMA address into a physical address by walking a three-level table tree held in memory. The levels are region, segment and page. A request brings the DMA address, the kind of access wanted and the anchor of the tree, which is a table origin plus a protection flag. The walker first checks the address against a configured window. It then reads one 64-bit entry per level through a simple read port. At each level it checks the entry and either steps down to the next table or stops.

The response gives the 4 KiB-aligned request address, the translated address, an address mask for the frame size, a two-bit permission and an error code. A segment entry with its large-frame flag set ends the walk early with a 1 MiB frame. Each failure class has its own error code. Any error also raises a sticky fault flag, which only reset clears. The walker handles one request at a time.

Top module: `dma_xlate_walker`

## Requirements
- R1: Walk order and table indexing.
  - The walk reads the region table, then the segment table, then the page table.
  - The region index is address bits [41:31], the segment index is bits [30:20] and the page index is bits [19:12].
  - Each entry is read at origin + 8 × index. Entries are read one at a time.
  - The next origin is entry bits [63:12] with 12 zero bits below them.
  - The low 12 bits of the anchor origin are ignored.
- R2: The response mask is 0xFFF when the walk ends at the page level, 0xFFFFF at the segment level and 0x7FFFFFFF at the region level.
- R3: An entry that is all zeros stops the walk with error code 1, permission 00 and translated address 0.
- R4: A nonzero entry with its valid bit (bit 0) clear stops the walk with permission 00 and translated address 0. It raises no walk error code.
- R5: A region entry must have its length field (bits [5:4]) equal to 2'b11 and its offset field (bits [7:6]) equal to 2'b00. Otherwise the walk stops with error code 2 and permission 00.
- R6: An entry whose next origin is zero stops the walk with error code 3 and permission 00.
- R7: Permission starts at read/write (2'b11).
  - It drops to read-only (2'b01) when the anchor protection flag or the protect bit (bit 1) of any entry that passes its checks is set.
  - It is never raised again within a walk.
- R8: A segment entry with its large-frame bit (bit 2) set completes the walk. The translated address is entry bits [63:20] joined with DMA address bits [19:0].
- R9: A page entry completes the walk with translated address = entry bits [63:12] followed by 12 zero bits. The response request address is the DMA address with bits [11:0] cleared.
- R10: A DMA address below the window base or above the window limit returns error code 4, permission 00 and mask 0. It makes no memory read, and done rises in the cycle after acceptance. An address equal to the base or to the limit is in range.
- R11: Access check.
  - The access field is a bit mask: bit 0 asks for read and bit 1 asks for write.
  - When the walk raised no error code, a nonzero access with no bit in common with the final permission gives error code 5.
- R12: Any nonzero error code sets the fault flag. The flag is visible with done and stays set until reset.
- R13: Handshake and response timing.
  - req_ready is high only while idle.
  - Done is a one-cycle pulse carrying the response.
  - At most one memory read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_addr | input | 64 | DMA address to translate |
| req_acc | input | 2 | Access wanted: bit 0 read, bit 1 write |
| req_org | input | 64 | Anchor origin of the region table |
| req_prot | input | 1 | Anchor protection flag |
| cfg_base | input | 64 | Lowest DMA address in the window |
| cfg_limit | input | 64 | Highest DMA address in the window |
| mem_rd | output | 1 | Entry read strobe, one cycle |
| mem_addr | output | 64 | Entry address for the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry returned by memory |
| done | output | 1 | Response valid pulse |
| rsp_iova | output | 64 | Request address aligned to 4 KiB |
| rsp_addr | output | 64 | Translated address |
| rsp_mask | output | 64 | Frame size minus one |
| rsp_perm | output | 2 | Final permission: 00 none, 01 read-only, 11 read/write |
| rsp_err | output | 3 | 0 ok, 1 zero entry, 2 bad length, 3 zero origin, 4 range, 5 protection |
| fn_err | output | 1 | Sticky fault flag |

## Verification
The hardest case to reach from the ports is a fault at a deep level combined with permission history from the levels above. One example is a zero-origin page entry after a protected segment. Another is a read or write against a tree that turned read-only only at its last level. Only a tree built to match the indices of the chosen address reaches these cases. So the bench rebuilds a sparse memory for each request. It places entries at the exact region, segment and page slots of the address and injects one fault class at a randomly chosen level, mixed with random protect and large-frame flags. Directed cases cover each fault at its own level and the window edges.

// File: rtl/dxw_pkg.sv
package dxw_pkg;

    parameter int ADDR_W    = 64;
    parameter int ENTRY_LG  = 3;
    parameter int PAGE_LG   = 12;
    parameter int SEG_LG    = 20;
    parameter int REG_LG    = 31;
    parameter int REG_TOP   = 41;

    localparam int RX_W  = REG_TOP - REG_LG + 1;
    localparam int SX_W  = REG_LG - SEG_LG;
    localparam int PX_W  = SEG_LG - PAGE_LG;
    localparam int IDX_W = (RX_W > SX_W) ? RX_W : SX_W;
    localparam int HI_W  = REG_TOP - PAGE_LG + 1;

    parameter int BIT_VALID = 0;
    parameter int BIT_PROT  = 1;
    parameter int BIT_FC    = 2;
    parameter int LEN_LSB   = 4;
    parameter int LEN_W     = 2;
    parameter int OFF_LSB   = 6;
    parameter int OFF_W     = 2;

    localparam logic [1:0] PERM_NONE = 2'b00;
    localparam logic [1:0] PERM_RO   = 2'b01;
    localparam logic [1:0] PERM_RW   = 2'b11;

    typedef enum logic [1:0] {
        LVL_PAGE = 2'd0,
        LVL_SEG  = 2'd1,
        LVL_REG  = 2'd2
    } level_e;

    typedef enum logic [2:0] {
        ERR_NONE      = 3'd0,
        ERR_BAD_ENTRY = 3'd1,
        ERR_BAD_LEN   = 3'd2,
        ERR_XLATE     = 3'd3,
        ERR_RANGE     = 3'd4,
        ERR_PROT      = 3'd5
    } err_e;

    typedef struct packed {
        logic              zero;
        logic              valid;
        logic              prot;
        logic              len_bad;
        logic              org_zero;
        logic              done_here;
        logic [ADDR_W-1:0] next_org;
        logic [ADDR_W-1:0] frame;
        logic [ADDR_W-1:0] mask;
    } dec_t;

    typedef struct packed {
        logic [ADDR_W-1:0] iova;
        logic [ADDR_W-1:0] xaddr;
        logic [ADDR_W-1:0] mask;
        logic [1:0]        perm;
        logic [2:0]        err;
    } rsp_t;

    function automatic logic [ADDR_W-1:0] level_mask(level_e lvl);
        case (lvl)
            LVL_PAGE: return (ADDR_W'(1) << PAGE_LG) - ADDR_W'(1);
            LVL_SEG:  return (ADDR_W'(1) << SEG_LG) - ADDR_W'(1);
            default:  return (ADDR_W'(1) << REG_LG) - ADDR_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/dxw_index_gen.sv
module dxw_index_gen
    import dxw_pkg::*;
(
    input  level_e            lvl,
    input  logic [HI_W-1:0]   dma_hi,
    input  logic [ADDR_W-1:0] org,
    output logic [ADDR_W-1:0] ent_addr
);

    logic [IDX_W-1:0] idx;

    always_comb begin
        case (lvl)
            LVL_REG:  idx = IDX_W'(dma_hi[REG_TOP-PAGE_LG : REG_LG-PAGE_LG]);
            LVL_SEG:  idx = IDX_W'(dma_hi[REG_LG-1-PAGE_LG : SEG_LG-PAGE_LG]);
            default:  idx = IDX_W'(dma_hi[SEG_LG-1-PAGE_LG : 0]);
        endcase
    end

    assign ent_addr = org + ADDR_W'({idx, {ENTRY_LG{1'b0}}});

endmodule

// File: rtl/dxw_entry_decode.sv
module dxw_entry_decode
    import dxw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  level_e            lvl,
    input  logic [SEG_LG-1:0] dma_lo,
    output dec_t              dec
);

    always_comb begin
        dec           = '0;
        dec.zero      = (entry == '0);
        dec.valid     = entry[BIT_VALID];
        dec.prot      = entry[BIT_PROT];
        dec.len_bad   = (lvl == LVL_REG) &&
                        ((entry[LEN_LSB +: LEN_W] != '1) ||
                         (entry[OFF_LSB +: OFF_W] != '0));
        dec.next_org  = {entry[ADDR_W-1:PAGE_LG], {PAGE_LG{1'b0}}};
        dec.org_zero  = (entry[ADDR_W-1:PAGE_LG] == '0);
        dec.mask      = level_mask(lvl);
        case (lvl)
            LVL_PAGE: begin
                dec.done_here = 1'b1;
                dec.frame     = {entry[ADDR_W-1:PAGE_LG], {PAGE_LG{1'b0}}};
            end
            LVL_SEG: begin
                dec.done_here = entry[BIT_FC];
                dec.frame     = {entry[ADDR_W-1:SEG_LG], dma_lo};
            end
            default: begin
                dec.done_here = 1'b0;
                dec.frame     = '0;
            end
        endcase
    end

endmodule

// File: rtl/dxw_step.sv
module dxw_step
    import dxw_pkg::*;
(
    input  dec_t              dec,
    input  logic [1:0]        perm_in,
    input  logic [1:0]        acc,
    output logic              stop,
    output logic [1:0]        perm_out,
    output err_e              err,
    output logic [ADDR_W-1:0] xaddr
);

    always_comb begin
        stop     = 1'b1;
        err      = ERR_NONE;
        perm_out = PERM_NONE;
        xaddr    = '0;
        if (dec.zero) begin
            err = ERR_BAD_ENTRY;
        end else if (!dec.valid) begin
            err = ERR_NONE;
        end else if (dec.len_bad) begin
            err = ERR_BAD_LEN;
        end else if (dec.org_zero) begin
            err = ERR_XLATE;
        end else begin
            perm_out = dec.prot ? (perm_in & PERM_RO) : perm_in;
            if (dec.done_here) begin
                xaddr = dec.frame;
            end else begin
                stop = 1'b0;
            end
        end
        if (stop && (err == ERR_NONE) && (acc != 2'b00) &&
            ((acc & perm_out) == 2'b00)) begin
            err = ERR_PROT;
        end
    end

endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
    import dxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    input  logic [1:0]        req_acc,
    input  logic [63:0]       req_org,
    input  logic              req_prot,
    input  logic [63:0]       cfg_base,
    input  logic [63:0]       cfg_limit,
    output logic              mem_rd,
    output logic [63:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata,
    output logic              done,
    output logic [63:0]       rsp_iova,
    output logic [63:0]       rsp_addr,
    output logic [63:0]       rsp_mask,
    output logic [1:0]        rsp_perm,
    output logic [2:0]        rsp_err,
    output logic              fn_err
);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DECODE,
        ST_DONE
    } state_e;

    localparam logic [ADDR_W-1:0] ORG_KEEP = ~((ADDR_W'(1) << PAGE_LG) - ADDR_W'(1));

    state_e            state_q;
    level_e            lvl_q;
    logic [ADDR_W-1:0] org_q;
    logic [ADDR_W-1:0] entry_q;
    logic [REG_TOP:0]  dma_q;
    logic [1:0]        acc_q;
    logic [1:0]        perm_q;
    rsp_t              rsp_q;
    logic              fn_err_q;

    dec_t              dec;
    logic              step_stop;
    logic [1:0]        step_perm;
    err_e              step_err;
    logic [ADDR_W-1:0] step_xaddr;
    logic              out_of_win;

    assign out_of_win = (req_addr < cfg_base) || (req_addr > cfg_limit);

    dxw_index_gen u_index (
        .lvl      (lvl_q),
        .dma_hi   (dma_q[REG_TOP:PAGE_LG]),
        .org      (org_q),
        .ent_addr (mem_addr)
    );

    dxw_entry_decode u_decode (
        .entry  (entry_q),
        .lvl    (lvl_q),
        .dma_lo (dma_q[SEG_LG-1:0]),
        .dec    (dec)
    );

    dxw_step u_step (
        .dec      (dec),
        .perm_in  (perm_q),
        .acc      (acc_q),
        .stop     (step_stop),
        .perm_out (step_perm),
        .err      (step_err),
        .xaddr    (step_xaddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            lvl_q    <= LVL_REG;
            org_q    <= '0;
            entry_q  <= '0;
            dma_q    <= '0;
            acc_q    <= '0;
            perm_q   <= PERM_NONE;
            rsp_q    <= '0;
            fn_err_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        dma_q      <= req_addr[REG_TOP:0];
                        acc_q      <= req_acc;
                        rsp_q.iova <= req_addr & ORG_KEEP;
                        if (out_of_win) begin
                            rsp_q.xaddr <= '0;
                            rsp_q.mask  <= '0;
                            rsp_q.perm  <= PERM_NONE;
                            rsp_q.err   <= ERR_RANGE;
                            fn_err_q    <= 1'b1;
                            state_q     <= ST_DONE;
                        end else begin
                            org_q   <= req_org & ORG_KEEP;
                            lvl_q   <= LVL_REG;
                            perm_q  <= req_prot ? PERM_RO : PERM_RW;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        entry_q <= mem_rdata;
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    perm_q <= step_perm;
                    if (step_stop) begin
                        rsp_q.xaddr <= step_xaddr;
                        rsp_q.mask  <= dec.mask;
                        rsp_q.perm  <= step_perm;
                        rsp_q.err   <= step_err;
                        if (step_err != ERR_NONE) begin
                            fn_err_q <= 1'b1;
                        end
                        state_q <= ST_DONE;
                    end else begin
                        org_q   <= dec.next_org;
                        lvl_q   <= level_e'(lvl_q - 2'd1);
                        state_q <= ST_ISSUE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_rd    = (state_q == ST_ISSUE);
    assign done      = (state_q == ST_DONE);
    assign rsp_iova  = rsp_q.iova;
    assign rsp_addr  = rsp_q.xaddr;
    assign rsp_mask  = rsp_q.mask;
    assign rsp_perm  = rsp_q.perm;
    assign rsp_err   = rsp_q.err;
    assign fn_err    = fn_err_q;

endmodule

// File: rtl/dxw_checker.sv
module dxw_checker
    import dxw_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic [63:0] cfg_base,
    input logic [63:0] cfg_limit,
    input logic        mem_rd,
    input logic        mem_rvalid,
    input logic        done,
    input logic [1:0]  rsp_perm,
    input logic [2:0]  rsp_err,
    input logic        fn_err
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (mem_rd) begin
            pend <= 1'b1;
        end else if (mem_rvalid) begin
            pend <= 1'b0;
        end
    end

    AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !pend); // R13

    AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_rd); // R13

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13

    AST_RANGE_QUICK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ((req_addr < cfg_base) || (req_addr > cfg_limit)))
        |=> (done && rsp_err == ERR_RANGE && !mem_rd)); // R10

    AST_WALK_ERR_NO_PERM: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_err != ERR_NONE && rsp_err != ERR_PROT) |-> rsp_perm == PERM_NONE); // R3

    AST_PERM_LEGAL: assert property (@(posedge clk) disable iff (rst)
        done |-> (rsp_perm == PERM_NONE || rsp_perm == PERM_RO || rsp_perm == PERM_RW)); // R7

    AST_FLAG_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (done && rsp_err != ERR_NONE) |-> fn_err); // R12

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        fn_err |=> fn_err); // R12

endmodule

bind dma_xlate_walker dxw_checker i_chk (.*);

// File: tb/test_dma_xlate_walker.sv
`timescale 1ns/1ps
module test_dma_xlate_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic [63:0] req_org = '0;
    logic        req_prot = 1'b0;
    logic [63:0] cfg_base = 64'h1000_0000;
    logic [63:0] cfg_limit = 64'h3_FFFF_FFFF;
    logic        mem_rd;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [63:0] rsp_iova, rsp_addr, rsp_mask;
    logic [1:0]  rsp_perm;
    logic [2:0]  rsp_err;
    logic        fn_err;

    int n_tests = 0;
    int n_fail  = 0;
    int n_reads = 0;
    bit exp_flag = 1'b0;

    logic [63:0] mem [logic [63:0]];

    typedef struct {
        logic [63:0] iova;
        logic [63:0] xaddr;
        logic [63:0] mask;
        logic [1:0]  perm;
        logic [2:0]  err;
        int          reads;
    } exp_t;

    always #10 clk = ~clk;

    dma_xlate_walker i_dma_xlate_walker (.*);

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] tent(input logic [63:0] org, input bit v,
            input bit p, input bit fc, input logic [1:0] len, input logic [1:0] off);
        return {org[63:12], 4'h0, off, len, 1'b0, fc, p, v};
    endfunction

    function automatic exp_t ref_walk(input logic [63:0] a, input logic [1:0] acc,
                                      input logic [63:0] org, input bit aprot);
        exp_t e;
        logic [63:0] to, ent, nto;
        logic [63:0] idx;
        int lvl;
        e.iova = {a[63:12], 12'h0};
        e.xaddr = '0;
        e.mask = '0;
        e.perm = 2'b00;
        e.err = 3'd0;
        e.reads = 0;
        if (a < cfg_base || a > cfg_limit) begin
            e.err = 3'd4;
            return e;
        end
        e.perm = aprot ? 2'b01 : 2'b11;
        to = {org[63:12], 12'h0};
        lvl = 2;
        while (1) begin
            idx = (lvl == 2) ? {53'h0, a[41:31]} :
                  (lvl == 1) ? {53'h0, a[30:20]} : {56'h0, a[19:12]};
            ent = rd(to + idx * 8);
            e.reads++;
            e.mask = (lvl == 2) ? 64'h7FFF_FFFF : (lvl == 1) ? 64'hF_FFFF : 64'hFFF;
            nto = {ent[63:12], 12'h0};
            if (ent == 0) begin e.err = 3'd1; e.perm = 2'b00; break; end
            if (!ent[0]) begin e.perm = 2'b00; break; end
            if (lvl == 2 && (ent[5:4] != 2'b11 || ent[7:6] != 2'b00)) begin
                e.err = 3'd2; e.perm = 2'b00; break;
            end
            if (nto == 0) begin e.err = 3'd3; e.perm = 2'b00; break; end
            if (ent[1]) e.perm = e.perm & 2'b01;
            if (lvl == 1 && ent[2]) begin e.xaddr = {ent[63:20], a[19:0]}; break; end
            if (lvl == 0) begin e.xaddr = nto; break; end
            to = nto;
            lvl--;
        end
        if (e.err == 0 && acc != 0 && (acc & e.perm) == 0) e.err = 3'd5;
        return e;
    endfunction

    task automatic build(input logic [63:0] a, input logic [63:0] rorg, input logic [63:0] rent,
                         input logic [63:0] sorg, input logic [63:0] sent,
                         input logic [63:0] porg, input logic [63:0] pent);
        mem.delete();
        mem[{rorg[63:12], 12'h0} + {53'h0, a[41:31]} * 8] = rent;
        mem[sorg + {53'h0, a[30:20]} * 8] = sent;
        mem[porg + {56'h0, a[19:12]} * 8] = pent;
    endtask

    // memory model: answers each strobe after a random delay
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd === 1'b1) begin
                logic [63:0] a;
                a = mem_addr;
                n_reads++;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata = rd(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata = '0;
            end
        end
    end

    task automatic run_case(input string tag, input logic [63:0] a, input logic [1:0] acc,
                            input logic [63:0] org, input bit aprot);
        exp_t e;
        int cyc;
        e = ref_walk(a, acc, org, aprot);
        @(negedge clk);
        chk("R13", "ready while idle", {63'h0, req_ready}, 64'h1);
        n_reads = 0;
        req_valid = 1'b1;
        req_addr = a;
        req_acc = acc;
        req_org = org;
        req_prot = aprot;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        if (!done) chk("R13", "busy not ready", {63'h0, req_ready}, 64'h0);
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        if (e.err == 3'd4) chk("R10", "cycles to done", 64'(cyc), 64'h0);
        chk("R9", "request address", rsp_iova, e.iova);
        chk(tag, "translated address", rsp_addr, e.xaddr);
        chk("R2", "mask", rsp_mask, e.mask);
        chk("R7", "permission", {62'h0, rsp_perm}, {62'h0, e.perm});
        chk(tag, "error code", {61'h0, rsp_err}, {61'h0, e.err});
        chk("R1", "entry reads", 64'(n_reads), 64'(e.reads));
        if (e.err != 0) exp_flag = 1'b1;
        chk("R12", "fault flag", {63'h0, fn_err}, {63'h0, exp_flag});
        @(negedge clk);
        chk("R13", "done pulse width", {63'h0, done}, 64'h0);
    endtask

    localparam logic [63:0] RO0 = 64'h0010_0000;
    localparam logic [63:0] SO0 = 64'h0100_0000;
    localparam logic [63:0] PO0 = 64'h0200_0000;
    localparam logic [63:0] FR0 = 64'h3_4567_8000;
    localparam logic [63:0] A0  = 64'h0000_0002_3456_7ABC;

    task automatic normal(input logic [63:0] a, input bit rp, input bit sp, input bit pp);
        build(a, RO0, tent(SO0, 1, rp, 0, 2'b11, 2'b00), SO0, tent(PO0, 1, sp, 0, 2'b00, 2'b00),
              PO0, tent(FR0, 1, pp, 0, 2'b00, 2'b00));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state
        chk("R13", "reset ready", {63'h0, req_ready}, 64'h1);
        chk("R13", "reset done", {63'h0, done}, 64'h0);
        chk("R12", "reset flag", {63'h0, fn_err}, 64'h0);
        chk("R1", "reset read strobe", {63'h0, mem_rd}, 64'h0);
        rst = 1'b0;

        // R9 full walk, R1 ignored low origin bits
        normal(A0, 0, 0, 0);
        run_case("R9", A0, 2'b01, RO0 | 64'h5A5, 1'b0);
        run_case("R9", A0, 2'b11, RO0, 1'b0);
        // R7 / R11 protection from page entry and anchor
        normal(A0, 0, 0, 1);
        run_case("R11", A0, 2'b10, RO0, 1'b0);
        run_case("R7", A0, 2'b01, RO0, 1'b0);
        normal(A0, 0, 0, 0);
        run_case("R7", A0, 2'b01, RO0, 1'b1);
        run_case("R11", A0, 2'b10, RO0, 1'b1);
        normal(A0, 1, 0, 0);
        run_case("R7", A0, 2'b11, RO0, 1'b0);
        // R8 large segment frame
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b11, 2'b00), SO0,
              tent(64'h7_8AB0_0000, 1, 0, 1, 2'b00, 2'b00), PO0, 64'h0);
        run_case("R8", A0, 2'b11, RO0, 1'b0);
        // R3 zero entries
        build(A0, RO0, 64'h0, SO0, 64'h0, PO0, 64'h0);
        run_case("R3", A0, 2'b00, RO0, 1'b0);
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b11, 2'b00), SO0,
              tent(PO0, 1, 0, 0, 2'b00, 2'b00), PO0, 64'h0);
        run_case("R3", A0, 2'b01, RO0, 1'b0);
        // R4 invalid nonzero segment entry
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b11, 2'b00), SO0,
              tent(PO0, 0, 0, 0, 2'b00, 2'b00), PO0, 64'h0);
        run_case("R4", A0, 2'b00, RO0, 1'b0);
        run_case("R4", A0, 2'b01, RO0, 1'b0);
        // R5 region length and offset
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b01, 2'b00), SO0, 64'h0, PO0, 64'h0);
        run_case("R5", A0, 2'b01, RO0, 1'b0);
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b11, 2'b10), SO0, 64'h0, PO0, 64'h0);
        run_case("R5", A0, 2'b01, RO0, 1'b0);
        // R6 zero next origin at region and page level
        build(A0, RO0, tent(64'h0, 1, 0, 0, 2'b11, 2'b00), SO0, 64'h0, PO0, 64'h0);
        run_case("R6", A0, 2'b01, RO0, 1'b0);
        build(A0, RO0, tent(SO0, 1, 0, 0, 2'b11, 2'b00), SO0,
              tent(PO0, 1, 1, 0, 2'b00, 2'b00), PO0, tent(64'h0, 1, 0, 0, 2'b00, 2'b00));
        run_case("R6", A0, 2'b01, RO0, 1'b0);
        // R10 window edges
        normal(cfg_base, 0, 0, 0);
        run_case("R10", cfg_base, 2'b01, RO0, 1'b0);
        normal(cfg_limit, 0, 0, 0);
        run_case("R10", cfg_limit, 2'b01, RO0, 1'b0);
        run_case("R10", cfg_base - 64'h1, 2'b01, RO0, 1'b0);
        run_case("R10", cfg_limit + 64'h1, 2'b00, RO0, 1'b0);

        // random trees with one injected fault class
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, rorg, sorg, porg, frm, rent, sent, pent;
            bit rp, sp, pp, fc;
            int f;
            if ($urandom_range(0, 9) == 0) a = {22'h0, 10'($urandom()), 32'($urandom())};
            else a = {30'h0, 2'($urandom_range(0, 3)), 32'($urandom())};
            rorg = RO0 + ({56'h0, 8'($urandom())} << 14);
            sorg = SO0 + ({56'h0, 8'($urandom())} << 14);
            porg = PO0 + ({56'h0, 8'($urandom())} << 12);
            frm  = {20'h0, 32'($urandom()), 12'h0} | 64'h1000;
            rp = ($urandom_range(0, 4) == 0);
            sp = ($urandom_range(0, 4) == 0);
            pp = ($urandom_range(0, 3) == 0);
            fc = ($urandom_range(0, 2) == 0);
            rent = tent(sorg, 1, rp, 0, 2'b11, 2'b00);
            sent = tent(porg, 1, sp, fc, 2'b00, 2'b00);
            pent = tent(frm, 1, pp, 0, 2'b00, 2'b00);
            f = $urandom_range(0, 15);
            case ($urandom_range(0, 2))
                0: case (f)
                       0: rent = 64'h0;
                       1: rent[0] = 1'b0;
                       2: rent[5:4] = 2'($urandom_range(0, 2));
                       3: rent[7:6] = 2'($urandom_range(1, 3));
                       4: rent = tent(64'h0, 1, rp, 0, 2'b11, 2'b00);
                       default: ;
                   endcase
                1: case (f)
                       0: sent = 64'h0;
                       1: sent[0] = 1'b0;
                       4: sent = tent(64'h0, 1, sp, fc, 2'b00, 2'b00);
                       default: ;
                   endcase
                default: case (f)
                       0: pent = 64'h0;
                       1: pent[0] = 1'b0;
                       4: pent = tent(64'h0, 1, pp, 0, 2'b00, 2'b00);
                       default: ;
                   endcase
            endcase
            build(a, rorg, rent, sorg, sent, porg, pent);
            run_case("R1", a, 2'($urandom_range(0, 3)),
                     rorg | {52'h0, 12'($urandom())}, ($urandom_range(0, 4) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R13 watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule